// File: doc/BRIEF.md
# Eight-bit E4M3 to single-precision converter

This block turns one 8-bit floating-point code in the 1-4-3 layout (one sign bit, a four-bit exponent with bias 7, a three-bit mantissa) into the IEEE-754 single-precision bit pattern of the same value. Every code has an exact single-precision image, so the conversion needs no rounding. The source format has no infinity. Exponent 15 together with mantissa 7 is the only not-a-number code for each sign. Every other code with exponent 15 is an ordinary normal number, and the largest of these is 448. A zero exponent marks a subnormal code. The block normalizes it with a leading-one search, and the result is a normal single-precision value.

Codes arrive on a valid/ready stream and results leave on another. In the default build one register stage sits between the two streams. A result stays on the output, unchanged, until the consumer takes it. A new code is accepted when that register is empty or is being drained in the same cycle. No code is ever dropped, and results come out in the order their codes were accepted. An upstream source may withdraw or change a code that has not been accepted yet. Setting the parameter `REG_OUT` to 0 removes the register and leaves a purely combinational path.

Top module: `e4m3_to_fp32`

## Requirements
- R1: Bit 7 of the code is the sign, bits 6:3 are the exponent e and bits 2:0 are the mantissa m. For e not 0 and not a NaN code, the output is (1 + m/8) x 2^(e-7): exponent field e+120, top three fraction bits m, all other fraction bits 0 (0x38 gives 0x3F800000, 0x40 gives 0x40000000, 0x30 gives 0x3F000000).
- R2: A code with e = 15 and m = 7 produces the quiet NaN 0x7FC00000 with the input sign copied into bit 31 (0x7F gives 0x7FC00000, 0xFF gives 0xFFC00000).
- R3: A code with e = 15 and m from 0 to 6 is an ordinary normal value (0x7E gives 0x43E00000, which is 448.0).
- R4: A code with e = 0 and m not 0 gives (m/8) x 2^-6 as an exact normal single-precision value (0x01 gives 0x3B000000, which is 2^-9).
- R5: Codes 0x00 and 0x80 give 0x00000000 and 0x80000000.
- R6: Bit 31 of every output equals bit 7 of the code that produced it (0xB8 gives 0xBF800000).
- R7: With `REG_OUT` = 1, a code accepted at a clock edge is presented on `out_valid`/`out_word` immediately after that edge.
- R8: While `out_valid` is high and `out_ready` is low, the output holds its word and `in_ready` is low. `in_ready` is high whenever the stage is empty or `out_ready` is high. Results come out in the order their codes were accepted, with none lost.
- R9: After reset `out_valid` is low and `in_ready` is high.
- R10: No output is a single-precision infinity (exponent field 0xFF with a zero fraction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A code is offered |
| in_ready | output | 1 | The block can take a code this cycle |
| in_code | input | 8 | Code in the 1-4-3 layout |
| out_valid | output | 1 | A converted word is offered |
| out_ready | input | 1 | The consumer takes the word this cycle |
| out_word | output | 32 | Single-precision bit pattern |

## Verification
The properties take for granted that `in_code` holds a defined value whenever `in_valid` is high. They place no rule on `out_ready`, which may drop in any cycle, including while a result is waiting. The stimulus changes inputs only on falling clock edges. It goes through all 256 codes in order, draws random codes from the whole byte range, and lowers `out_ready` at random so that the hold, stall and ordering behaviour is exercised. A directed prologue checks the single-cycle latency, then holds the output stalled for several cycles before releasing it.

// File: rtl/e4m3_cvt_pkg.sv
package e4m3_cvt_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int SP_BIAS   = 127;
  localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_SUB  = 2'd1,
    CLS_NORM = 2'd2,
    CLS_NAN  = 2'd3
  } code_class_e;
endpackage

// File: rtl/e4m3_field_split.sv
module e4m3_field_split
  import e4m3_cvt_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int MAN_W = 3
) (
  input  logic [EXP_W+MAN_W:0] code_i,
  output logic                 sign_o,
  output logic [EXP_W-1:0]     exp_o,
  output logic [MAN_W-1:0]     man_o,
  output code_class_e          cls_o
);
  localparam int MSB = EXP_W + MAN_W;

  assign sign_o = code_i[MSB];
  assign exp_o  = code_i[MSB-1:MAN_W];
  assign man_o  = code_i[MAN_W-1:0];

  always_comb begin
    if ((&exp_o) && (&man_o))   cls_o = CLS_NAN;
    else if (exp_o != '0)       cls_o = CLS_NORM;
    else if (man_o != '0)       cls_o = CLS_SUB;
    else                        cls_o = CLS_ZERO;
  end
endmodule

// File: rtl/e4m3_sub_norm.sv
module e4m3_sub_norm
  import e4m3_cvt_pkg::*;
#(
  parameter int MAN_W = 3,
  localparam int LEAD_W = (MAN_W > 1) ? $clog2(MAN_W) : 1
) (
  input  logic [MAN_W-1:0]     man_i,
  output logic [LEAD_W-1:0]    lead_o,
  output logic [SP_FRAC_W-1:0] frac_o
);
  always_comb begin
    lead_o = '0;
    for (int i = 0; i < MAN_W; i++) begin
      if (man_i[i]) lead_o = LEAD_W'(i);
    end
  end

  // The leading one moves past the top of the fraction field and drops out.
  assign frac_o = {{(SP_FRAC_W-MAN_W){1'b0}}, man_i} << (SP_FRAC_W - int'(lead_o));

  always_comb begin
    if (man_i != '0) begin
      assert_lead_one_R4: assert ((man_i >> lead_o) == MAN_W'(1));
    end
  end
endmodule

// File: rtl/e4m3_fp32_pack.sv
module e4m3_fp32_pack
  import e4m3_cvt_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int MAN_W = 3,
  parameter int BIAS  = 7,
  localparam int LEAD_W = (MAN_W > 1) ? $clog2(MAN_W) : 1
) (
  input  logic                 sign_i,
  input  logic [EXP_W-1:0]     exp_i,
  input  logic [MAN_W-1:0]     man_i,
  input  code_class_e          cls_i,
  input  logic [LEAD_W-1:0]    lead_i,
  input  logic [SP_FRAC_W-1:0] sub_frac_i,
  output logic [SP_W-1:0]      word_o
);
  localparam int NORM_OFF = SP_BIAS - BIAS;
  localparam int SUB_BASE = SP_BIAS - BIAS + 1 - MAN_W;

  always_comb begin
    unique case (cls_i)
      CLS_ZERO: word_o = {sign_i, {(SP_W-1){1'b0}}};
      CLS_NAN:  word_o = {sign_i, {SP_EXP_W{1'b1}}, 1'b1, {(SP_FRAC_W-1){1'b0}}};
      CLS_NORM: word_o = {sign_i, SP_EXP_W'(int'(exp_i) + NORM_OFF),
                          man_i, {(SP_FRAC_W-MAN_W){1'b0}}};
      default:  word_o = {sign_i, SP_EXP_W'(SUB_BASE + int'(lead_i)), sub_frac_i};
    endcase
  end

  always_comb begin
    if (cls_i != CLS_NAN) begin
      assert_no_inf_R10: assert (word_o[SP_W-2:SP_FRAC_W] != {SP_EXP_W{1'b1}});
    end
  end
endmodule

// File: rtl/e4m3_to_fp32.sv
module e4m3_to_fp32
  import e4m3_cvt_pkg::*;
#(
  parameter int EXP_W   = 4,
  parameter int MAN_W   = 3,
  parameter int BIAS    = 7,
  parameter bit REG_OUT = 1'b1,
  localparam int CODE_W = 1 + EXP_W + MAN_W,
  localparam int LEAD_W = (MAN_W > 1) ? $clog2(MAN_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SP_W-1:0]   out_word
);
  logic                 f_sign;
  logic [EXP_W-1:0]     f_exp;
  logic [MAN_W-1:0]     f_man;
  code_class_e          f_cls;
  logic [LEAD_W-1:0]    s_lead;
  logic [SP_FRAC_W-1:0] s_frac;
  logic [SP_W-1:0]      word_c;

  e4m3_field_split #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_split (
    .code_i(in_code), .sign_o(f_sign), .exp_o(f_exp), .man_o(f_man), .cls_o(f_cls)
  );

  e4m3_sub_norm #(.MAN_W(MAN_W)) u_norm (
    .man_i(f_man), .lead_o(s_lead), .frac_o(s_frac)
  );

  e4m3_fp32_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)) u_pack (
    .sign_i(f_sign), .exp_i(f_exp), .man_i(f_man), .cls_i(f_cls),
    .lead_i(s_lead), .sub_frac_i(s_frac), .word_o(word_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic            vld_q;
      logic [SP_W-1:0] word_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_word  = word_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          word_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) word_q <= word_c;
        end
      end

      assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
      assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
      assert_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_word[SP_W-1] == $past(in_code[CODE_W-1])));
      assert_nan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (&in_code[CODE_W-2:0]))
        |=> (out_word[SP_W-2:0] == 31'h7FC00000));
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_word  = word_c;
    end
  endgenerate
endmodule

// File: tb/e4m3_to_fp32_bench.sv
module e4m3_to_fp32_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_code = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_word;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] pend_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  e4m3_to_fp32 u_e4m3_to_fp32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word)
  );

  // Value of a code as n x 2^-9, then placed into single precision.
  function automatic logic [31:0] ref_word(input logic [7:0] b);
    logic [3:0] e;
    logic [2:0] m;
    int n, k;
    logic [31:0] frac;
    e = b[6:3];
    m = b[2:0];
    if (e == 4'd15 && m == 3'd7) return {b[7], 31'h7FC00000};
    n = (e == 0) ? int'(m) : ((8 + int'(m)) << (int'(e) - 1));
    if (n == 0) return {b[7], 31'h0};
    k = 0;
    for (int i = 0; i < 20; i++) if (n >= (1 << i)) k = i;
    frac = 32'(n - (1 << k)) << (23 - k);
    return {b[7], 8'(k + 118), frac[22:0]};
  endfunction

  function automatic string ref_tag(input logic [7:0] b);
    if (b[6:0] == 7'h7F) return "R2";
    if (b[6:3] == 4'd15) return "R3";
    if (b[6:3] == 4'd0 && b[2:0] != 0) return "R4";
    if (b[6:0] == 7'h00) return "R5";
    return "R1";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Inputs set at the falling edge; handshakes recorded for the next rising edge.
  task automatic step(input bit v, input logic [7:0] c, input bit rdy);
    logic [7:0] b;
    @(negedge clk);
    in_valid  = v;
    in_code   = c;
    out_ready = rdy;
    #1;
    if (out_valid && out_ready) begin
      if (pend_q.size() == 0) begin
        check(1'b0, "R8", out_word, 32'h0);
      end else begin
        b = pend_q.pop_front();
        check(out_word == ref_word(b), ref_tag(b), out_word, ref_word(b));
        check(out_word[31] == b[7], "R6", {31'h0, out_word[31]}, {31'h0, b[7]});
        check(!(out_word[30:23] == 8'hFF && out_word[22:0] == 0), "R10",
              out_word, 32'h7F800000);
      end
    end
    if (in_valid && in_ready) pend_q.push_back(in_code);
  endtask

  initial begin
    int held_cnt;
    logic [31:0] held;
    bit stalled;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R9", {30'h0, out_valid, in_ready}, 32'h1);
    rst_n = 1'b1;

    // R7: single-cycle latency, then R8: hold under stall.
    @(negedge clk);
    in_valid = 1'b1; in_code = 8'h38; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid && out_word == 32'h3F800000, "R7", out_word, 32'h3F800000);
    held = out_word;
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_code = 8'hFF;
      @(negedge clk);
      #1;
      check(out_valid && out_word == held, "R8", out_word, held);
      check(!in_ready, "R8", {31'h0, in_ready}, 32'h0);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R8", {31'h0, out_valid}, 32'h0);

    // Directed codes named by the requirements.
    step(1, 8'h38, 1); step(1, 8'hB8, 1); step(1, 8'h40, 1); step(1, 8'h30, 1);
    step(1, 8'h7E, 1); step(1, 8'h7F, 1); step(1, 8'hFF, 1); step(1, 8'h01, 1);
    step(1, 8'h00, 1); step(1, 8'h80, 1); step(1, 8'h07, 1); step(1, 8'hFE, 1);
    // Every code once, with full throughput.
    for (int c = 0; c < 256; c++) step(1, 8'(c), 1);
    // Random codes with random stalls; stall hold checked as it happens.
    stalled = 1'b0;
    held_cnt = 0;
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, 8'($urandom), ($urandom % 10) > 2);
      if (stalled) begin
        check(out_valid && out_word == held, "R8", out_word, held);
        held_cnt++;
      end
      stalled = out_valid && !out_ready;
      held = out_word;
    end
    for (int i = 0; i < 4; i++) step(0, 8'h00, 1);
    check(pend_q.size() == 0 && held_cnt > 0, "R8", 32'(pend_q.size()), 32'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule